// File: doc/BRIEF.md
# Filtered Quadrature Decoder with Index Qualification

This block turns the raw phase signals of an incremental encoder, plus its active-low marker input, into single-cycle count-up and count-down pulses, a running direction flag and a one-cycle index strobe. It feeds a position counter, which sits outside this block. The resolution is chosen at run time: one, two or four counts per full quadrature cycle. A plain step-and-direction mode is also available.

In the quadrature modes, every input passes through a synchronizer and then a debounce filter. The filter samples on a filter-clock enable that runs either at the system clock rate or at half that rate. A new level is passed on only after it has been seen on a fixed number of consecutive filter samples. The index can be qualified in one of two ways. In the first, it is accepted only while the filtered phases are equal, either both high or both low. In the second, it is taken as a raw falling edge. Step-and-direction mode always uses the raw edge.

Top module: `quad_decoder`

## Requirements
- R1: While rst_ni is low, and after its release with no input activity, up_o, dn_o and idx_o are 0 and dir_o is 1.
- R2: mode_i encodes 00 step/direction, 01 x1, 10 x2 and 11 x4. In x4, one forward cycle of {a_i,b_i} = 00,10,11,01,00 gives exactly 4 up pulses. The reverse order gives 4 down pulses.
- R3: x2 counts only on edges of the filtered A signal. x1 counts only on rising edges of the filtered A signal. An A edge means up when A rises with B low or falls with B high; otherwise it means down. As a result, a forward cycle gives 2 up pulses in x2 and 1 in x1, and a reverse cycle gives the same number of down pulses.
- R4: up_o and dn_o each last one clock and are never high together. dir_o becomes 1 with an up pulse and 0 with a down pulse, and it changes at no other time.
- R5: A filtered input takes a new level only after STABLE_CNT consecutive filter samples that differ from its current level. With div2_i=0 and STABLE_CNT=3, a 2-clock pulse on a_i gives no count, while a 3-clock pulse gives one up pulse and then one down pulse.
- R6: With div2_i=1, the filter samples only on every second clock. A 3-clock pulse on a_i then gives no count, while a full cycle held 12 clocks per state still gives 4 counts in x4.
- R7: If both filtered phases change on the same filter sample, no pulse is issued. Decoding then continues from the new state.
- R8: In mode 00, the filter is bypassed. Every rising edge of the synchronized a_i gives one pulse, even if a_i is high for a single clock. The pulse is up when b_i is high and down when b_i is low.
- R9: With sync_idx_i=1 in a quadrature mode, idx_o pulses once per low period of the filtered index. It pulses on the first clock at which the filtered index is low and the filtered A equals the filtered B. If A and B differ for the whole low period, there is no pulse.
- R10: With sync_idx_i=0, or in mode 00, idx_o pulses one clock after the synchronized idx_ni falls, whatever the state of A and B. A 1-clock low pulse is enough.
- R11: idx_o is high for a single clock per accepted index, even when idx_ni stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 1 | Encoder phase A, or the step input in mode 00 |
| b_i | input | 1 | Encoder phase B, or the direction input in mode 00 (1 = up) |
| idx_ni | input | 1 | Encoder marker, active low |
| mode_i | input | 2 | Decode mode: 00 step/dir, 01 x1, 10 x2, 11 x4 |
| div2_i | input | 1 | 1 halves the filter sample rate |
| sync_idx_i | input | 1 | 1 enables phase-qualified index in the quadrature modes |
| up_o | output | 1 | One-cycle count-up pulse |
| dn_o | output | 1 | One-cycle count-down pulse |
| dir_o | output | 1 | Direction of the last count, 1 = up |
| idx_o | output | 1 | One-cycle qualified index strobe |

## Verification
The bench builds the block with STABLE_CNT=3 and SYNC_STAGES=2. With these values, the rejection boundary of the filter falls at pulse widths of two and three clocks. That makes it possible to show, with short stimuli, a pulse that is rejected, a pulse that is accepted, and a pulse that is rejected only because the sample rate is halved. The same settings keep the latency from an edge to a count short. This lets the bench walk each resolution mode forwards and backwards, drive a simultaneous two-phase jump, and show an index that is held off until the phases agree, all within a few hundred clocks.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    QM_STEPDIR = 2'b00,
    QM_X1      = 2'b01,
    QM_X2      = 2'b10,
    QM_X4      = 2'b11
  } qmode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } step_t;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_d_o
);
  // one extra stage gives the delayed copy used for edge detection
  logic [STAGES:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= {(STAGES+1){RST_VAL}};
    else         st_q <= {st_q[STAGES-1:0], d_i};
  end

  assign q_o   = st_q[STAGES-1];
  assign q_d_o = st_q[STAGES];
endmodule

// File: rtl/qdec_tick.sv
module qdec_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div2_i,
  output logic tick_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  assign tick_o = ~div2_i | tog_q;
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
  parameter int   STABLE  = 3,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic d_i,
  output logic q_o
);
  localparam int            CW   = (STABLE > 1) ? $clog2(STABLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o   <= RST_VAL;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (d_i != q_o) begin
        if (cnt_q == LAST) begin
          q_o   <= d_i;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  qmode_e mode_i,
  input  logic   fa_i,
  input  logic   fb_i,
  input  logic   sa_i,
  input  logic   sa_d_i,
  input  logic   sb_i,
  output logic   up_o,
  output logic   dn_o,
  output logic   dir_o
);
  logic  pa_q, pb_q;
  logic  da, db;
  step_t nxt;

  assign da = fa_i ^ pa_q;
  assign db = fb_i ^ pb_q;

  always_comb begin
    nxt = '0;
    if (mode_i == QM_STEPDIR) begin
      if (sa_i & ~sa_d_i) begin
        nxt.up = sb_i;
        nxt.dn = ~sb_i;
      end
    end else if (da & ~db) begin
      // A edge: up when A and B now differ
      if (mode_i != QM_X1 || fa_i) begin
        nxt.up = fa_i ^ fb_i;
        nxt.dn = ~(fa_i ^ fb_i);
      end
    end else if (db & ~da & (mode_i == QM_X4)) begin
      nxt.up = ~(fa_i ^ fb_i);
      nxt.dn = fa_i ^ fb_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      up_o  <= 1'b0;
      dn_o  <= 1'b0;
      dir_o <= 1'b1;
    end else begin
      pa_q <= fa_i;
      pb_q <= fb_i;
      up_o <= nxt.up;
      dn_o <= nxt.dn;
      if (nxt.up)      dir_o <= 1'b1;
      else if (nxt.dn) dir_o <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_index.sv
module qdec_index (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_en_i,
  input  logic fi_i,
  input  logic fa_i,
  input  logic fb_i,
  input  logic si_i,
  input  logic si_d_i,
  output logic idx_o
);
  logic armed_q;
  logic fire;

  assign fire = sync_en_i ? (armed_q & ~fi_i & ~(fa_i ^ fb_i))
                          : (~si_i & si_d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      idx_o   <= 1'b0;
    end else begin
      idx_o <= fire;
      if (fi_i)                  armed_q <= 1'b1;
      else if (sync_en_i & fire) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/quad_decoder.sv
module quad_decoder
  import qdec_pkg::*;
#(
  parameter int STABLE_CNT  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  input  logic       idx_ni,
  input  logic [1:0] mode_i,
  input  logic       div2_i,
  input  logic       sync_idx_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       dir_o,
  output logic       idx_o
);
  localparam int           NCH     = 3;
  localparam logic [NCH-1:0] RST_RAW = 3'b100;

  qmode_e         mode;
  logic [NCH-1:0] raw, syn, syn_d, filt;
  logic           tick;

  assign mode = qmode_e'(mode_i);
  assign raw  = {idx_ni, b_i, a_i};

  qdec_sync #(.W(NCH), .STAGES(SYNC_STAGES), .RST_VAL(RST_RAW)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(syn), .q_d_o(syn_d)
  );

  qdec_tick u_tick (.clk_i, .rst_ni, .div2_i, .tick_o(tick));

  for (genvar g = 0; g < NCH; g++) begin : g_filt
    qdec_filter #(.STABLE(STABLE_CNT), .RST_VAL(RST_RAW[g])) u_filt (
      .clk_i, .rst_ni, .tick_i(tick), .d_i(syn[g]), .q_o(filt[g])
    );
  end

  qdec_step u_step (
    .clk_i, .rst_ni, .mode_i(mode),
    .fa_i(filt[0]), .fb_i(filt[1]),
    .sa_i(syn[0]), .sa_d_i(syn_d[0]), .sb_i(syn[1]),
    .up_o, .dn_o, .dir_o
  );

  qdec_index u_index (
    .clk_i, .rst_ni,
    .sync_en_i(sync_idx_i & (mode != QM_STEPDIR)),
    .fi_i(filt[2]), .fa_i(filt[0]), .fb_i(filt[1]),
    .si_i(syn[2]), .si_d_i(syn_d[2]),
    .idx_o
  );
endmodule

// File: rtl/qdec_sva.sv
module qdec_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic up_o,
  input logic dn_o,
  input logic dir_o,
  input logic idx_o
);
  a_r4_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));
  a_r4_up_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |=> !up_o);
  a_r4_dn_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |=> !dn_o);
  a_r4_dir_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> dir_o);
  a_r4_dir_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |-> !dir_o);
  a_r4_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_o) |-> (up_o || dn_o));
  a_r11_idx_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o |=> !idx_o);
endmodule

bind quad_decoder qdec_sva u_qdec_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .up_o(up_o), .dn_o(dn_o),
  .dir_o(dir_o), .idx_o(idx_o)
);

// File: tb/quad_decoder_bench.sv
module quad_decoder_bench;
  localparam int CLK_P  = 10;
  localparam int STABLE = 3;
  localparam int SYNC   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a = 1'b0, b = 1'b0, idx_n = 1'b1, div2 = 1'b0, sidx = 1'b0;
  logic [1:0] mode = 2'b11;
  logic up, dn, dir, idxo;

  quad_decoder #(.STABLE_CNT(STABLE), .SYNC_STAGES(SYNC)) u_quad_decoder (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .idx_ni(idx_n),
    .mode_i(mode), .div2_i(div2), .sync_idx_i(sidx),
    .up_o(up), .dn_o(dn), .dir_o(dir), .idx_o(idxo)
  );

  always #(CLK_P/2) clk = ~clk;

  int    checks = 0, fails = 0;
  int    n_up = 0, n_dn = 0, n_idx = 0;
  string cur_req = "R1";
  bit    live = 1'b0, done = 1'b0;

  // behavioural reference
  logic qa[$], qb[$], qi[$];
  logic mf[3];
  int   mc[3];
  logic pa, pb, mtog, marm, mu, md, mdir, mi;

  task automatic m_init();
    qa = {}; qb = {}; qi = {};
    for (int k = 0; k <= SYNC; k++) begin
      qa.push_back(1'b0); qb.push_back(1'b0); qi.push_back(1'b1);
    end
    mf[0] = 1'b0; mf[1] = 1'b0; mf[2] = 1'b1;
    for (int k = 0; k < 3; k++) mc[k] = 0;
    pa = 1'b0; pb = 1'b0; mtog = 1'b0; marm = 1'b1;
    mu = 1'b0; md = 1'b0; mdir = 1'b1; mi = 1'b0;
  endtask

  task automatic m_step();
    logic s[3];
    logic sad, sid, tk, nu, nd, fire, se, ch_a, ch_b;
    s[0] = qa[SYNC-1]; s[1] = qb[SYNC-1]; s[2] = qi[SYNC-1];
    sad = qa[SYNC]; sid = qi[SYNC];
    tk = !div2 || mtog;
    nu = 1'b0; nd = 1'b0;
    ch_a = (mf[0] != pa); ch_b = (mf[1] != pb);
    if (mode == 2'b00) begin
      if (s[0] && !sad) begin nu = s[1]; nd = !s[1]; end
    end else if (ch_a && !ch_b) begin
      if (mode != 2'b01 || mf[0]) begin nu = (mf[0] != mf[1]); nd = !nu; end
    end else if (ch_b && !ch_a && mode == 2'b11) begin
      nu = (mf[0] == mf[1]); nd = !nu;
    end
    if (nu) mdir = 1'b1; else if (nd) mdir = 1'b0;
    mu = nu; md = nd;
    se = sidx && (mode != 2'b00);
    fire = se ? (marm && !mf[2] && (mf[0] == mf[1])) : (!s[2] && sid);
    if (mf[2]) marm = 1'b1; else if (se && fire) marm = 1'b0;
    mi = fire;
    pa = mf[0]; pb = mf[1];
    if (tk) begin
      for (int k = 0; k < 3; k++) begin
        if (s[k] != mf[k]) begin
          if (mc[k] == STABLE - 1) begin mf[k] = s[k]; mc[k] = 0; end
          else mc[k]++;
        end else mc[k] = 0;
      end
    end
    qa.push_front(a); void'(qa.pop_back());
    qb.push_front(b); void'(qb.pop_back());
    qi.push_front(idx_n); void'(qi.pop_back());
    mtog = !mtog;
  endtask

  initial m_init();
  always @(posedge clk) begin
    if (!rst_n) m_init();
    else        m_step();
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      chk(cur_req, "model up_o", up, mu);
      chk(cur_req, "model dn_o", dn, md);
      chk(cur_req, "model dir_o", dir, mdir);
      chk(cur_req, "model idx_o", idxo, mi);
      n_up  += up;
      n_dn  += dn;
      n_idx += idxo;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ab(input logic na, input logic nb, input int hold);
    @(negedge clk);
    a = na; b = nb;
    idle(hold - 1);
  endtask

  task automatic clr();
    n_up = 0; n_dn = 0; n_idx = 0;
  endtask

  task automatic fwd(input int h);
    ab(1, 0, h); ab(1, 1, h); ab(0, 1, h); ab(0, 0, h); idle(10);
  endtask

  task automatic rev(input int h);
    ab(0, 1, h); ab(1, 1, h); ab(1, 0, h); ab(0, 0, h); idle(10);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog %s actual=timeout expected=finish", cur_req);
      summary();
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 during reset
    chk("R1", "up_o in reset", up, 0);
    chk("R1", "dn_o in reset", dn, 0);
    chk("R1", "idx_o in reset", idxo, 0);
    chk("R1", "dir_o in reset", dir, 1);
    rst_n = 1'b1; live = 1'b1;
    idle(12);
    chk("R1", "dir_o after reset", dir, 1);
    chk("R1", "no pulses after reset", n_up + n_dn + n_idx, 0);

    cur_req = "R2"; clr();
    fwd(8);
    chk("R2", "x4 forward up", n_up, 4);
    chk("R2", "x4 forward dn", n_dn, 0);
    clr(); rev(8);
    chk("R2", "x4 reverse dn", n_dn, 4);
    chk("R2", "x4 reverse up", n_up, 0);
    chk("R4", "dir_o after reverse", dir, 0);

    cur_req = "R3"; mode = 2'b10; clr();
    fwd(8);
    chk("R3", "x2 forward up", n_up, 2);
    clr(); rev(8);
    chk("R3", "x2 reverse dn", n_dn, 2);
    mode = 2'b01; clr();
    fwd(8);
    chk("R3", "x1 forward up", n_up, 1);
    chk("R4", "dir_o after x1 forward", dir, 1);
    clr(); rev(8);
    chk("R3", "x1 reverse dn", n_dn, 1);
    chk("R3", "x1 reverse up", n_up, 0);

    cur_req = "R5"; mode = 2'b11; clr();
    ab(1, 0, 2); ab(0, 0, 12);
    chk("R5", "2-clock glitch counts", n_up + n_dn, 0);
    clr();
    ab(1, 0, 3); ab(0, 0, 12);
    chk("R5", "3-clock pulse up", n_up, 1);
    chk("R5", "3-clock pulse dn", n_dn, 1);

    cur_req = "R6"; div2 = 1'b1; idle(2); clr();
    ab(1, 0, 3); ab(0, 0, 14);
    chk("R6", "3-clock pulse halved rate", n_up + n_dn, 0);
    clr(); fwd(12); idle(4);
    chk("R6", "halved rate forward up", n_up, 4);
    div2 = 1'b0; idle(4);

    cur_req = "R7"; clr();
    ab(1, 1, 12);
    chk("R7", "double jump counts", n_up + n_dn, 0);
    ab(0, 1, 12); ab(0, 0, 12);
    chk("R7", "resume after jump up", n_up, 2);
    chk("R7", "resume after jump dn", n_dn, 0);

    cur_req = "R8"; mode = 2'b00; idle(4); clr();
    ab(0, 1, 4);
    for (int k = 0; k < 3; k++) begin ab(1, 1, 1); ab(0, 1, 3); end
    idle(8);
    chk("R8", "step up pulses", n_up, 3);
    clr();
    ab(0, 0, 4);
    for (int k = 0; k < 2; k++) begin ab(1, 0, 1); ab(0, 0, 3); end
    idle(8);
    chk("R8", "step down pulses", n_dn, 2);
    chk("R8", "step up when b low", n_up, 0);
    chk("R4", "dir_o after step down", dir, 0);

    cur_req = "R9"; mode = 2'b11; sidx = 1'b1; idle(12);
    ab(1, 0, 12); clr();
    idx_n = 1'b0; idle(12); idx_n = 1'b1; idle(12);
    chk("R9", "index with A!=B", n_idx, 0);
    idx_n = 1'b0; idle(12);
    ab(1, 1, 12); ab(0, 1, 12); ab(0, 0, 12);
    idx_n = 1'b1; idle(12);
    chk("R9", "index accepted once when phases agree", n_idx, 1);
    clr();
    idx_n = 1'b0; idle(2); idx_n = 1'b1; idle(12);
    chk("R9", "2-clock index glitch", n_idx, 0);
    idx_n = 1'b0; idle(12); idx_n = 1'b1; idle(12);
    chk("R9", "index at phase 00", n_idx, 1);

    cur_req = "R10"; sidx = 1'b0; idle(2);
    ab(1, 0, 12); clr();
    idx_n = 1'b0; idle(1); idx_n = 1'b1; idle(10);
    chk("R10", "async 1-clock index", n_idx, 1);
    mode = 2'b00; sidx = 1'b1; idle(4); clr();
    idx_n = 1'b0; idle(12); idx_n = 1'b1; idle(10);
    chk("R11", "held-low index single strobe", n_idx, 1);
    chk("R10", "step mode forces async index", n_idx, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule